// File: doc/BRIEF.md
# Multiplexed Code Fetch Bus Controller

This block lets an 8-bit processor core fetch code bytes from an external memory over a shared byte-wide port. The core presents a 16-bit fetch address with a request. The controller drives the low address byte on the shared port and raises an address strobe, so that an external transparent latch holds that byte. The high byte goes out on a dedicated port for the whole access. The controller then releases the shared port and pulls an active-low code-read enable, which drives the output enable of the external memory. The memory answers on the shared port, and the controller hands the byte back to the core with a one-cycle valid pulse.

An on-chip code enable input decides where low addresses go. When it is low, every fetch goes to the external bus. When it is high, addresses below `INT_BYTES` are marked for on-chip memory with a one-cycle local pulse, and the pins stay quiet. The sequencer has six named states. IDLE goes to ADDR on an external request, or to LOCAL on an on-chip one. ADDR lasts `ADDR_CYC` clocks and then moves to GAP. GAP lasts `GAP_CYC` clocks and then moves to READ. READ lasts `RD_CYC` clocks and then moves to DONE. DONE and LOCAL each last one clock and then return to IDLE.

Top module: `exb_code_bus`

## Requirements
- R1: During and right after reset, `fetch_ready` is 1, `ale` is 0, `psen_n` is 1, `ad_oe` is 0 and `fetch_valid` is 0.
- R2: A request is accepted on a clock edge where `fetch_ready` and `fetch_req` are both 1. It goes external when `onchip_en` is 0 or when the address is at least `INT_BYTES`. In that case `ale` is 1 for exactly `ADDR_CYC` clocks, starting with the clock after acceptance.
- R3: From the clock after acceptance until the end of the valid cycle of an external access, `addr_hi` equals address bits 15..8.
- R4: During the address phase and the `GAP_CYC` clocks that follow it, `ad_oe` is 1 and `ad_out` equals address bits 7..0. During the gap, `ale` is 0 and `psen_n` is 1.
- R5: After the gap, `psen_n` is 0 for exactly `RD_CYC` clocks.
- R6: The byte on `ad_in` is sampled only on the last clock of the read phase. The clock right after the read phase shows it on `fetch_data` with `fetch_valid` at 1 for that single clock.
- R7: `fetch_ready` is 0 from the clock after acceptance until the valid (or local) cycle has ended. Requests and address changes during that time have no effect.
- R8: An on-chip fetch (`onchip_en` 1 and address below `INT_BYTES`) gives a single `local_hit` clock right after acceptance. During that clock there is no `ale` and no `psen_n`, and the block is ready again on the clock after.
- R9: `ale` is never 1 while `psen_n` is 0, and `ad_oe` is never 1 while `psen_n` is 0.
- R10: With `onchip_en` high, address `INT_BYTES-1` stays on chip and address `INT_BYTES` goes external. With `onchip_en` low, address 0 goes external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Core fetch request |
| fetch_addr | input | 16 | Core fetch address |
| onchip_en | input | 1 | 1: low addresses served on chip; 0: all fetches external |
| fetch_ready | output | 1 | Controller idle, request can be taken |
| fetch_valid | output | 1 | One-cycle pulse, `fetch_data` holds the code byte |
| fetch_data | output | 8 | Returned code byte |
| local_hit | output | 1 | One-cycle pulse, fetch belongs to on-chip memory |
| ad_out | output | 8 | Shared port output value (low address byte) |
| ad_oe | output | 1 | Shared port drive enable |
| ad_in | input | 8 | Shared port input value (code byte from memory) |
| addr_hi | output | 8 | Dedicated high address port |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code-read enable to memory, active low |

## Verification
A behavioural bench latch and memory return a byte computed from the latched low byte and the high port. The latch only sees the low byte while the strobe is high, so a wrong or late address phase changes the returned data. The memory answers with a junk value on every read clock except the last one, so sampling one clock early shows up at once. The address patterns include all-zero, all-one and alternating bits, the two on-chip boundary addresses with the enable high and low, and a request held high through a whole access with a changing address. These tell apart correct latching, correct sampling time, correct routing and the busy lock-out. Back-to-back requests held high across several accesses check that the controller rearms on the clock after it returns to idle.

// File: rtl/exb_pkg.sv
package exb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_GAP   = 3'd2,
        ST_READ  = 3'd3,
        ST_DONE  = 3'd4,
        ST_LOCAL = 3'd5
    } exb_state_e;
endpackage

// File: rtl/exb_phase_cnt.sv
// Counts clocks spent in the current phase; cleared on every phase change.
module exb_phase_cnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/exb_addr_reg.sv
// Holds the accepted fetch address and the captured code byte.
module exb_addr_reg #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic          cap,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (load) addr_q <= addr_in;
            if (cap)  data_q <= din;
        end
    end
endmodule

// File: rtl/exb_seq.sv
// Access sequencer: state register process plus separate output decode.
module exb_seq
    import exb_pkg::*;
#(
    parameter int AW        = 16,
    parameter int CW        = 3,
    parameter int ADDR_CYC  = 2,
    parameter int GAP_CYC   = 1,
    parameter int RD_CYC    = 3,
    parameter int INT_BYTES = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] req_addr,
    input  logic          onchip_en,
    input  logic [CW-1:0] cnt,
    output logic          load,
    output logic          cap,
    output logic          clr,
    output logic          ale,
    output logic          psen_n,
    output logic          ad_oe,
    output logic          ready,
    output logic          valid,
    output logic          local_hit
);
    localparam logic [CW-1:0] A_LAST = CW'(ADDR_CYC - 1);
    localparam logic [CW-1:0] G_LAST = CW'(GAP_CYC - 1);
    localparam logic [CW-1:0] R_LAST = CW'(RD_CYC - 1);

    exb_state_e state_q, state_d;
    logic       is_local;

    assign is_local = onchip_en && (32'(req_addr) < INT_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        cap     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    load    = 1'b1;
                    state_d = is_local ? ST_LOCAL : ST_ADDR;
                end
            end
            ST_ADDR:  if (cnt == A_LAST) state_d = ST_GAP;
            ST_GAP:   if (cnt == G_LAST) state_d = ST_READ;
            ST_READ: begin
                if (cnt == R_LAST) begin
                    cap     = 1'b1;
                    state_d = ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_LOCAL: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign clr = (state_d != state_q);

    always_comb begin
        ale       = 1'b0;
        psen_n    = 1'b1;
        ad_oe     = 1'b0;
        ready     = 1'b0;
        valid     = 1'b0;
        local_hit = 1'b0;
        unique case (state_q)
            ST_IDLE:  ready = 1'b1;
            ST_ADDR: begin
                ale   = 1'b1;
                ad_oe = 1'b1;
            end
            ST_GAP:   ad_oe  = 1'b1;
            ST_READ:  psen_n = 1'b0;
            ST_DONE:  valid  = 1'b1;
            ST_LOCAL: local_hit = 1'b1;
            default:  ready = 1'b0;
        endcase
    end

    a_r9_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale && !psen_n));
    a_r9_port_released: assert property (@(posedge clk) disable iff (!rst_n)
        !(ad_oe && !psen_n));
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    a_r6_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(!psen_n));
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req) |=> !ready);
    a_r8_local_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        local_hit |-> (psen_n && !ale && !ad_oe));
    a_r8_local_returns: assert property (@(posedge clk) disable iff (!rst_n)
        local_hit |=> ready);
endmodule

// File: rtl/exb_code_bus.sv
module exb_code_bus #(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int ADDR_CYC  = 2,
    parameter int GAP_CYC   = 1,
    parameter int RD_CYC    = 3,
    parameter int INT_BYTES = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_req,
    input  logic [AW-1:0]    fetch_addr,
    input  logic             onchip_en,
    output logic             fetch_ready,
    output logic             fetch_valid,
    output logic [DW-1:0]    fetch_data,
    output logic             local_hit,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    input  logic [DW-1:0]    ad_in,
    output logic [AW-DW-1:0] addr_hi,
    output logic             ale,
    output logic             psen_n
);
    localparam int MAX_A = (ADDR_CYC > GAP_CYC) ? ADDR_CYC : GAP_CYC;
    localparam int MAX_C = (MAX_A > RD_CYC) ? MAX_A : RD_CYC;
    localparam int CW    = $clog2(MAX_C + 1);

    logic          load, cap, clr;
    logic [CW-1:0] cnt;
    logic [AW-1:0] addr_q;

    exb_phase_cnt #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cnt(cnt)
    );

    exb_addr_reg #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .load(load), .addr_in(fetch_addr),
        .cap(cap), .din(ad_in), .addr_q(addr_q), .data_q(fetch_data)
    );

    exb_seq #(
        .AW(AW), .CW(CW), .ADDR_CYC(ADDR_CYC), .GAP_CYC(GAP_CYC),
        .RD_CYC(RD_CYC), .INT_BYTES(INT_BYTES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req(fetch_req), .req_addr(fetch_addr),
        .onchip_en(onchip_en), .cnt(cnt), .load(load), .cap(cap), .clr(clr),
        .ale(ale), .psen_n(psen_n), .ad_oe(ad_oe), .ready(fetch_ready),
        .valid(fetch_valid), .local_hit(local_hit)
    );

    assign ad_out  = addr_q[DW-1:0];
    assign addr_hi = addr_q[AW-1:DW];

    a_r3_high_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_ready && $past(!fetch_ready)) |-> $stable(addr_hi));
    a_r4_low_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && $past(ad_oe)) |-> $stable(ad_out));
endmodule

// File: tb/tb_exb_code_bus.sv
module tb_exb_code_bus;
    localparam int A  = 2;
    localparam int G  = 1;
    localparam int R  = 3;
    localparam int IB = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        onchip_en = 1'b0;
    logic        fetch_ready, fetch_valid, local_hit, ad_oe, ale, psen_n;
    logic [7:0]  fetch_data, ad_out, ad_in, addr_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    exb_code_bus #(.ADDR_CYC(A), .GAP_CYC(G), .RD_CYC(R), .INT_BYTES(IB)) dut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .onchip_en(onchip_en), .fetch_ready(fetch_ready), .fetch_valid(fetch_valid),
        .fetch_data(fetch_data), .local_hit(local_hit), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi), .ale(ale), .psen_n(psen_n)
    );

    function automatic logic [7:0] rom_byte(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
    endfunction

    // External transparent latch and memory with an access delay.
    logic [7:0] lat_lo = 8'h00;
    int         rd_cnt = 0;
    always @(negedge clk) begin
        if (ale && ad_oe) lat_lo <= ad_out;
        if (!psen_n) rd_cnt <= rd_cnt + 1;
        else         rd_cnt <= 0;
    end
    assign ad_in = psen_n ? 8'hFF : ((rd_cnt == R) ? rom_byte({addr_hi, lat_lo}) : 8'hEE);

    // Reference model: cycles elapsed since acceptance.
    int          m_t = -1;
    bit          m_loc = 0;
    logic [15:0] m_addr = '0;
    always @(posedge clk) begin
        if (!rst_n) m_t <= -1;
        else if (m_t < 0) begin
            if (fetch_req) begin
                m_t    <= 0;
                m_addr <= fetch_addr;
                m_loc  <= onchip_en && (int'(fetch_addr) < IB);
            end
        end else if (m_loc || m_t == A + G + R) m_t <= -1;
        else m_t <= m_t + 1;
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ext;
            ext = (m_t >= 0) && !m_loc;
            chk("R7", "fetch_ready", 32'(fetch_ready), 32'(m_t < 0));
            chk("R8", "local_hit",   32'(local_hit),   32'(m_t == 0 && m_loc));
            chk("R2", "ale",         32'(ale),         32'(ext && m_t < A));
            chk("R9", "ad_oe",       32'(ad_oe),       32'(ext && m_t < A + G));
            chk("R5", "psen_n",      32'(psen_n),      32'(!(ext && m_t >= A + G && m_t < A + G + R)));
            chk("R6", "fetch_valid", 32'(fetch_valid), 32'(ext && m_t == A + G + R));
            if (ext && m_t < A + G) chk("R4", "ad_out", 32'(ad_out), 32'(m_addr[7:0]));
            if (ext) chk("R3", "addr_hi", 32'(addr_hi), 32'(m_addr[15:8]));
            if (ext && m_t == A + G + R)
                chk("R6", "fetch_data", 32'(fetch_data), 32'(rom_byte(m_addr)));
        end
    end

    task automatic fetch(input logic [15:0] a, input bit oe, input bit hold, output int ale_cyc);
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a; onchip_en = oe; ale_cyc = 0;
        @(negedge clk);
        if (!hold) fetch_req = 1'b0;
        else fetch_addr = ~a;
        while (!fetch_ready) begin
            if (ale) ale_cyc++;
            @(negedge clk);
        end
        fetch_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (2) @(negedge clk);
        // R1: state held in reset
        chk("R1", "ready",  32'(fetch_ready), 32'd1);
        chk("R1", "ale",    32'(ale),         32'd0);
        chk("R1", "psen_n", 32'(psen_n),      32'd1);
        chk("R1", "ad_oe",  32'(ad_oe),       32'd0);
        chk("R1", "valid",  32'(fetch_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        fetch(16'h0000, 1'b0, 1'b0, n); chk("R10", "ale cycles @0 forced external", 32'(n), 32'(A));
        fetch(16'hFFFF, 1'b0, 1'b0, n);
        fetch(16'hA55A, 1'b1, 1'b0, n);
        fetch(16'h5AA5, 1'b0, 1'b1, n);  // R7: request held with changing address
        fetch(16'h0FFF, 1'b1, 1'b0, n); chk("R10", "ale cycles @IB-1 on chip", 32'(n), 32'd0);
        fetch(16'h1000, 1'b1, 1'b0, n); chk("R10", "ale cycles @IB external", 32'(n), 32'(A));
        fetch(16'h0FFF, 1'b0, 1'b0, n); chk("R10", "ale cycles @IB-1 forced external", 32'(n), 32'(A));
        fetch(16'h0123, 1'b1, 1'b1, n);  // R8 local with held request
        for (int i = 0; i < 8; i++) begin
            fetch(16'(i * 16'h2F17 + 16'h0311), i[0], i[1], n);
        end
        // back-to-back accesses with request held high
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = 16'h2468; onchip_en = 1'b0;
        repeat (3 * (A + G + R + 2)) @(negedge clk);
        fetch_req = 1'b0;
        repeat (A + G + R + 3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule